// File: doc/BRIEF.md
# ADC Result Threshold Comparator

This block watches the stream of conversion results leaving an analog-to-digital converter. It holds four compare units. Each unit follows one sample slot and tests every result written to that slot against a programmed 12-bit threshold, using either a "below" or an "at or above" test. A unit raises its compare flag only after a programmed number of consecutive results from its slot have passed. The flag stays set until software clears it. An optional interrupt request follows the flag.

Units 0 and 1 can be joined into an in-window detector, and so can units 2 and 3. The even unit of the pair then also requires its odd partner's test to pass on the same result, so its flag marks a run of results that fall inside a band. Results arrive on a single valid strobe that carries a slot number and data. Configuration is written one unit at a time through a 32-bit word.

Top module: `adc_thr_cmp`

## Requirements
- R1: After reset, every compare flag and every interrupt request output is 0.
- R2: A configuration word's match-count field, bits [12:9], holds the required run length minus one. The flag of an enabled unit is set on the edge that accepts the (field+1)-th consecutive passing result from its slot. A field of 0 sets the flag on the first passing result.
- R3: The condition bit, bit 1, selects the test. With 0 a result passes when data < value. With 1 it passes when data >= value. The value is bits [27:16], so a result equal to the value passes only with the bit set to 1.
- R4: A result from a unit's selected slot (bits [8:4]) that fails the test restarts that unit's run from zero. Results carrying any other slot number leave the run unchanged.
- R5: The edge that sets a flag also restarts the run, so a further full run is needed before the flag can be set again. A set flag holds until cleared.
- R6: Bit 2 of unit 0's word enables window mode. Unit 0's result then passes only when unit 1's test, with unit 1's value and condition, also passes on that same data. Bit 2 of unit 2's word pairs units 2 and 3 in the same way. Bit 2 of an odd unit's word has no effect.
- R7: The interrupt request of unit n is high in exactly the cycles in which flag n is set and bit 3 of unit n's word is 1.
- R8: A status write clears flag n when bit 4+n of the status data is 1. Status bits [3:0] have no effect. When a flag is set and cleared on the same edge, it ends up set.
- R9: Any configuration write restarts that unit's run. Writing an all-zero word disables the unit, and a disabled unit never sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_slot | input | 5 | Sample slot of the result |
| res_data | input | 12 | Result value |
| cfg_we | input | 1 | Write a configuration word |
| cfg_unit | input | 2 | Unit addressed by the write |
| cfg_wdata | input | 32 | Configuration word: en[0], cond[1], window[2], irq_en[3], slot[8:4], count[12:9], value[27:16] |
| stat_we | input | 1 | Write to the interrupt status register |
| stat_wdata | input | 8 | Status data; bits [7:4] clear flags 0..3 |
| cmp_flag | output | 4 | Compare flags |
| cmp_irq | output | 4 | Compare interrupt requests |

## Verification
Assertions check on every cycle how each unit's run counter reacts to each input. A failing hit clears it. Traffic on other slots leaves it alone. It never exceeds the programmed limit. A completed run sets the flag and restarts the count. A disabled unit holds zero, and a clear without a coincident set drops the flag. Some behaviour appears only in the bench's scenarios, because there the result stream is compared with an independent model. These are the exact run lengths and the equality boundary of both tests. They also include the window pairing across two units and the inert window bit on odd units. The last group is the masking of the interrupt, the ignored low status bits, and the set-over-clear priority.

// File: rtl/adc_thr_pkg.sv
// Shared widths, configuration-word layout and its decoder for the
// threshold comparator. Assumes a 32-bit configuration word.
package adc_thr_pkg;
    localparam int RES_W    = 12;
    localparam int SLOT_W   = 5;
    localparam int MCNT_W   = 4;
    localparam int CFG_W    = 32;
    localparam int EN_BIT   = 0;
    localparam int GE_BIT   = 1;
    localparam int WIN_BIT  = 2;
    localparam int IE_BIT   = 3;
    localparam int SLOT_LSB = 4;
    localparam int MCNT_LSB = SLOT_LSB + SLOT_W;
    localparam int VAL_LSB  = 16;
    localparam int STAT_LSB = 4;

    typedef struct packed {
        logic [RES_W-1:0]  value;
        logic [MCNT_W-1:0] mcnt;
        logic [SLOT_W-1:0] slot;
        logic              irq_en;
        logic              win;
        logic              ge;
        logic              en;
    } unit_cfg_t;

    // Unpack a raw configuration word into its fields.
    function automatic unit_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        unit_cfg_t c;
        c.en     = w[EN_BIT];
        c.ge     = w[GE_BIT];
        c.win    = w[WIN_BIT];
        c.irq_en = w[IE_BIT];
        c.slot   = w[SLOT_LSB +: SLOT_W];
        c.mcnt   = w[MCNT_LSB +: MCNT_W];
        c.value  = w[VAL_LSB +: RES_W];
        return c;
    endfunction
endpackage

// File: rtl/adc_thr_cond.sv
// Threshold test for one unit: passes when data is below the value
// (ge = 0) or at/above it (ge = 1). Purely combinational.
module adc_thr_cond #(
    parameter int W = 12
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] value,
    input  logic         ge,
    output logic         pass
);
    // Select the comparison direction.
    always_comb begin
        pass = ge ? (data >= value) : (data < value);
    end
endmodule

// File: rtl/adc_thr_run.sv
// Consecutive-match counter and sticky flag for one unit. Assumes hit
// already includes the valid strobe and the slot match; en, mcnt are
// the unit's registered configuration; load marks a configuration write.
module adc_thr_run #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic             pass,
    input  logic             load,
    input  logic [CNT_W-1:0] mcnt,
    input  logic             clr,
    output logic             flag
);
    logic [CNT_W-1:0] cnt;
    logic             fire;

    // A run completes on a passing hit when the count equals the limit.
    always_comb begin
        fire = en && !load && hit && pass && (cnt == mcnt);
    end

    // Track the length of the current run of passing hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load || !en) begin
            cnt <= '0;
        end else if (hit) begin
            if (!pass || fire) cnt <= '0;
            else               cnt <= cnt + 1'b1;
        end
    end

    // Sticky flag: a completed run sets it, a clear drops it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (fire) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    assert_fire_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag);
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= mcnt);
    assert_fail_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !pass) |=> (cnt == '0));
    assert_other_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !load && en) |=> $stable(cnt));
    assert_rerun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt == '0));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fire) |=> !flag);
    assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

// File: rtl/adc_thr_cmp.sv
// Four-unit ADC result threshold comparator. Holds per-unit configuration,
// evaluates each result against every unit, joins even/odd pairs in window
// mode and drives sticky flags plus masked interrupt requests.
// Assumes NUM_UNITS is even and at most four status clear bits.
module adc_thr_cmp
    import adc_thr_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    localparam int UNIT_W   = $clog2(NUM_UNITS),
    localparam int STAT_W   = STAT_LSB + NUM_UNITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_valid,
    input  logic [SLOT_W-1:0]    res_slot,
    input  logic [RES_W-1:0]     res_data,
    input  logic                 cfg_we,
    input  logic [UNIT_W-1:0]    cfg_unit,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 stat_we,
    input  logic [STAT_W-1:0]    stat_wdata,
    output logic [NUM_UNITS-1:0] cmp_flag,
    output logic [NUM_UNITS-1:0] cmp_irq
);
    unit_cfg_t            cfg_q [NUM_UNITS];
    logic [NUM_UNITS-1:0] pass_own;
    logic [NUM_UNITS-1:0] pass_eff;
    logic [NUM_UNITS-1:0] unused_win;
    logic                 unused_bits;

    assign unused_bits = ^{cfg_wdata[CFG_W-1:VAL_LSB+RES_W],
                           cfg_wdata[VAL_LSB-1:MCNT_LSB+MCNT_W],
                           stat_wdata[STAT_LSB-1:0], unused_win};

    // Configuration registers, one word per unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_UNITS; k++) cfg_q[k] <= '0;
        end else if (cfg_we) begin
            cfg_q[cfg_unit] <= decode_cfg(cfg_wdata);
        end
    end

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        logic hit;
        logic load;
        logic clr;

        adc_thr_cond #(.W(RES_W)) u_cond (
            .data  (res_data),
            .value (cfg_q[i].value),
            .ge    (cfg_q[i].ge),
            .pass  (pass_own[i])
        );

        if (i % 2 == 0) begin : g_lead
            // Window mode also demands the partner's test on the same data.
            assign pass_eff[i]   = pass_own[i] && (!cfg_q[i].win || pass_own[i+1]);
            assign unused_win[i] = 1'b0;
        end else begin : g_partner
            assign pass_eff[i]   = pass_own[i];
            assign unused_win[i] = cfg_q[i].win;
        end

        assign hit  = res_valid && (res_slot == cfg_q[i].slot);
        assign load = cfg_we && (cfg_unit == UNIT_W'(i));
        assign clr  = stat_we && stat_wdata[STAT_LSB+i];

        adc_thr_run #(.CNT_W(MCNT_W)) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cfg_q[i].en),
            .hit   (hit),
            .pass  (pass_eff[i]),
            .load  (load),
            .mcnt  (cfg_q[i].mcnt),
            .clr   (clr),
            .flag  (cmp_flag[i])
        );

        assign cmp_irq[i] = cmp_flag[i] && cfg_q[i].irq_en;
    end
endmodule

// File: tb/adc_thr_cmp_tb.sv
// Scoreboard bench: the driver updates a requirement-level model and
// queues the expected outputs; the monitor compares them after each edge.
module adc_thr_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_valid;
    logic [4:0]  res_slot;
    logic [11:0] res_data;
    logic        cfg_we;
    logic [1:0]  cfg_unit;
    logic [31:0] cfg_wdata;
    logic        stat_we;
    logic [7:0]  stat_wdata;
    logic [3:0]  cmp_flag;
    logic [3:0]  cmp_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];

    logic [31:0] m_cfg [4];
    int          m_cnt [4];
    logic [3:0]  m_flag;

    always #5 clk = ~clk;

    adc_thr_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
        .res_data(res_data), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
        .cfg_wdata(cfg_wdata), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
    );

    function automatic logic [31:0] mk(bit en, bit ge, bit win, bit ie,
                                       int slot, int cnt, int val);
        return (32'(val) << 16) | (32'(cnt) << 9) | (32'(slot) << 4) |
               (32'(ie) << 3) | (32'(win) << 2) | (32'(ge) << 1) | 32'(en);
    endfunction

    function automatic bit tst(int u, logic [11:0] d);
        logic [11:0] v;
        v = m_cfg[u][27:16];
        return m_cfg[u][1] ? (d >= v) : (d < v);
    endfunction

    function automatic logic [7:0] expected();
        logic [3:0] ie;
        for (int u = 0; u < 4; u++) ie[u] = m_cfg[u][3];
        return {m_flag & ie, m_flag};
    endfunction

    task automatic push(string tag);
        q_exp.push_back(expected());
        q_tag.push_back(tag);
    endtask

    // One cycle of result and/or status traffic, with the model advanced.
    task automatic step(bit rv, int slot, logic [11:0] d, bit sw,
                        logic [7:0] swd, string tag);
        bit p [4];
        res_valid = rv; res_slot = 5'(slot); res_data = d;
        stat_we = sw; stat_wdata = swd;
        for (int u = 0; u < 4; u++) p[u] = tst(u, d);
        for (int u = 0; u < 4; u++) begin
            bit eff, hit, fire;
            eff = p[u];
            if (u % 2 == 0 && m_cfg[u][2]) eff = eff && p[u+1];
            hit  = rv && m_cfg[u][0] && (slot == int'(m_cfg[u][8:4]));
            fire = hit && eff && (m_cnt[u] == int'(m_cfg[u][12:9]));
            if (!m_cfg[u][0])  m_cnt[u] = 0;
            else if (hit)      m_cnt[u] = (eff && !fire) ? m_cnt[u] + 1 : 0;
            if (fire)                  m_flag[u] = 1'b1;
            else if (sw && swd[4+u])   m_flag[u] = 1'b0;
        end
        @(negedge clk);
        res_valid = 1'b0; stat_we = 1'b0;
        push(tag);
    endtask

    task automatic res(int slot, int d, string tag);
        step(1'b1, slot, 12'(d), 1'b0, 8'h00, tag);
    endtask

    task automatic stat(logic [7:0] w, string tag);
        step(1'b0, 0, 12'h000, 1'b1, w, tag);
    endtask

    task automatic cfg(int u, logic [31:0] w, string tag);
        cfg_we = 1'b1; cfg_unit = 2'(u); cfg_wdata = w;
        m_cfg[u] = w; m_cnt[u] = 0;
        @(negedge clk);
        cfg_we = 1'b0;
        push(tag);
    endtask

    // Monitor: compare queued expectations shortly after each edge.
    always @(negedge clk) begin
        #1;
        while (q_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({cmp_irq, cmp_flag} !== e) begin
                fails++;
                $display("FAIL %s: irq/flag actual %b/%b expected %b/%b",
                         t, cmp_irq, cmp_flag, e[7:4], e[3:0]);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; res_valid = 1'b0; res_slot = '0; res_data = '0;
        cfg_we = 1'b0; cfg_unit = '0; cfg_wdata = '0; stat_we = 1'b0; stat_wdata = '0;
        for (int u = 0; u < 4; u++) begin m_cfg[u] = '0; m_cnt[u] = 0; end
        m_flag = '0;
        repeat (3) @(negedge clk);
        push("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: three consecutive passes (field 2), at/above 0x800 on slot 5
        cfg(0, mk(1, 1, 0, 0, 5, 2, 12'h800), "R2 cfg");
        res(5, 12'h900, "R2 first pass");
        res(5, 12'h800, "R2 second pass");
        res(5, 12'hFFF, "R2 third pass sets flag");

        // R4: slot 3 below 0x100, field 2; foreign slot and a fail
        cfg(1, mk(1, 0, 0, 0, 3, 2, 12'h100), "R4 cfg");
        res(3, 12'h050, "R4 pass 1");
        res(3, 12'h050, "R4 pass 2");
        res(7, 12'h000, "R4 other slot no effect");
        res(3, 12'h200, "R4 fail restarts");
        res(3, 12'h0FF, "R4 pass 1 again");
        res(3, 12'h000, "R4 pass 2 again");
        res(3, 12'h010, "R4 pass 3 sets flag");

        // R3 and R7: equality boundary, irq enabled on unit 2 only
        cfg(2, mk(1, 1, 0, 1, 1, 0, 12'h400), "R7 cfg unit2");
        cfg(3, mk(1, 0, 0, 0, 1, 0, 12'h400), "R3 cfg unit3");
        res(1, 12'h3FF, "R3 below value: lt sets flag3 only");
        res(1, 12'h400, "R3 equal value: ge sets flag2 and R7 irq2");

        // R8: low status bits ignored, high bits clear
        stat(8'h0F, "R8 low status bits ignored");
        stat(8'h30, "R8 clear flags 0 and 1");
        step(1'b1, 1, 12'h400, 1'b1, 8'hC0, "R8 set wins over clear on flag2");
        stat(8'hF0, "R8 clear all");

        // R5: a new full run is needed after a flag
        res(5, 12'h900, "R5 pass 1");
        res(5, 12'h900, "R5 pass 2");
        res(5, 12'h900, "R5 pass 3 flag");
        stat(8'h10, "R5 clear flag0");
        res(5, 12'h900, "R5 new run 1");
        res(5, 12'h900, "R5 new run 2 no flag");
        res(5, 12'h900, "R5 new run 3 flag");
        stat(8'hF0, "R5 clear");

        // R6: window 0x300 <= d < 0x600 on slot 9, two in a row
        cfg(0, mk(1, 1, 1, 0, 9, 1, 12'h300), "R6 cfg lead");
        cfg(1, mk(1, 0, 1, 0, 12, 0, 12'h600), "R6 cfg partner, win bit inert");
        res(9, 12'h700, "R6 above window");
        res(9, 12'h700, "R6 above window no flag");
        res(9, 12'h200, "R6 below window no flag");
        res(9, 12'h400, "R6 inside 1");
        res(9, 12'h5FF, "R6 inside 2 sets flag0");
        res(12, 12'h000, "R6 partner own slot independent");
        stat(8'hF0, "R6 clear");
        cfg(2, mk(1, 1, 1, 1, 2, 0, 12'h100), "R6 cfg pair 2/3 lead");
        cfg(3, mk(1, 0, 0, 0, 6, 0, 12'h200), "R6 cfg pair 2/3 partner");
        res(2, 12'h250, "R6 pair2 outside");
        res(2, 12'h150, "R6 pair2 inside sets flag2");
        stat(8'hF0, "R6 clear pair2");

        // R9: zero write disables; any write restarts a run
        cfg(0, mk(1, 1, 0, 0, 5, 2, 12'h800), "R9 cfg");
        res(5, 12'h900, "R9 pass 1");
        res(5, 12'h900, "R9 pass 2");
        cfg(0, 32'h0, "R9 zero write");
        res(0, 12'h000, "R9 disabled ignores slot 0");
        res(5, 12'h900, "R9 disabled no flag");
        cfg(0, mk(1, 1, 0, 0, 5, 2, 12'h800), "R9 re-enable");
        res(5, 12'h900, "R9 run 1");
        res(5, 12'h900, "R9 run 2 no flag");
        res(5, 12'h900, "R9 run 3 flag");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule